// File: doc/BRIEF.md
# Single/Double Precision Format Converter

This block converts one IEEE 754 binary floating-point value per cycle between single and double precision. A direction input selects widening (single to double) or narrowing (double to single). The operand is 64 bits wide; when widening, only its low 32 bits carry the single-precision value. The result appears one clock after the input strobe, together with four exception flags: invalid, overflow, underflow and inexact.

Widening is always exact. Subnormal singles are renormalised into normal doubles. Narrowing rounds to nearest, ties to even. Overflow is judged after rounding. Tininess is judged before rounding. A mode input chooses which rule decides underflow: with the trap enabled, any tiny nonzero result flags underflow; with the trap disabled, underflow also needs the denormalised, rounded result to be inexact.

A NaN keeps its sign and is carried across formats by left alignment. The top fraction bits are copied. Narrowing drops the surplus low bits and widening fills the new low bits with zeros. The quiet bit of the result is always set. A signaling NaN input raises invalid.

Top module: `fmt_convert`

## Requirements
- R1: The converted value and flags appear on the outputs one cycle after a cycle with `in_valid` high, with `out_valid` high for that one cycle. Outputs hold their value while `out_valid` is low.
- R2: Widening (`narrow`=0) of a finite nonzero single is exact. A normal single gets exponent rebiased by +896 and fraction padded with 29 zero bits. A subnormal single is renormalised into a normal double. No flag is raised.
- R3: Widening a NaN (exponent 0xFF, nonzero fraction) gives exponent 0x7FF, the same sign, and fraction = {1, source fraction bits [21:0], 29 zeros}. Invalid is raised only when source fraction bit 22 (the quiet bit) is 0.
- R4: Narrowing (`narrow`=1) a NaN (exponent 0x7FF, nonzero fraction) gives exponent 0xFF, the same sign, and fraction = {1, source fraction bits [50:29]}. Invalid is raised only when source fraction bit 51 is 0.
- R5: Narrowing a value in the single normal range rounds the 52-bit fraction to 23 bits, to nearest with ties to even. Inexact is raised exactly when discarded bits are nonzero.
- R6: A narrowed finite value whose rounded exponent exceeds 254 becomes an infinity of the same sign, with both overflow and inexact raised.
- R7: A narrowed nonzero value below 2^-126 in magnitude is denormalised to a 2^-149 grid and rounded to nearest-even. The result may become zero or the smallest normal.
- R8: With `uf_trap_en`=1, every narrowed nonzero value below 2^-126 raises underflow, even when exact.
- R9: With `uf_trap_en`=0, underflow is raised only for a tiny value whose rounded result is inexact.
- R10: Zeros and infinities convert to the same-signed zero or infinity in either direction with no flag.
- R11: A narrowed result is placed in result bits [31:0] with bits [63:32] zero. When widening, operand bits [63:32] have no effect.
- R12: While reset is asserted, `out_valid`, `result` and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| narrow | input | 1 | 1: double to single, 0: single to double |
| uf_trap_en | input | 1 | Underflow trap enabled; selects the underflow rule |
| operand | input | 64 | Source value (single in bits [31:0] when widening) |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 64 | Converted value (single in bits [31:0] when narrowing) |
| flag_invalid | output | 1 | Signaling NaN input |
| flag_overflow | output | 1 | Rounded result overflowed to infinity |
| flag_underflow | output | 1 | Tiny result, per the selected rule |
| flag_inexact | output | 1 | Result differs from the exact value |

## Verification
The hardest cases to reach are the narrowing inputs that sit right at the underflow border. One example is a value just below 2^-126 that rounds up to the smallest normal yet is still tiny. Another is an exactly representable tiny value, whose underflow flag depends only on the trap mode. The stimulus builds these doubles directly from their exponent and fraction bits. It places the guard and sticky bits at chosen positions, including an exact 2^-150 tie that must round to zero. Each borderline operand is applied under both trap modes.

// File: rtl/fmt_convert.sv
module fmt_convert (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        narrow,
  input  logic        uf_trap_en,
  input  logic [63:0] operand,
  output logic        out_valid,
  output logic [63:0] result,
  output logic        flag_invalid,
  output logic        flag_overflow,
  output logic        flag_underflow,
  output logic        flag_inexact
);

  // widening path
  logic        ws;
  logic [7:0]  we;
  logic [22:0] wf;
  logic [4:0]  wp;
  logic [51:0] wfrac;
  logic [63:0] w_res;
  logic        w_inv;

  assign ws = operand[31];
  assign we = operand[30:23];
  assign wf = operand[22:0];
  assign wfrac = {29'b0, wf} << (6'd52 - {1'b0, wp});

  always_comb begin
    wp = 5'd0;
    for (int i = 0; i < 23; i++)
      if (wf[i]) wp = 5'(i);
  end

  always_comb begin
    w_inv = 1'b0;
    if (we == 8'hFF) begin
      if (wf == 23'b0) w_res = {ws, 11'h7FF, 52'b0};
      else begin
        w_res = {ws, 11'h7FF, 1'b1, wf[21:0], 29'b0};
        w_inv = ~wf[22];
      end
    end else if (we == 8'h00) begin
      if (wf == 23'b0) w_res = {ws, 63'b0};
      else             w_res = {ws, {6'b0, wp} + 11'd874, wfrac};
    end else begin
      w_res = {ws, {3'b0, we} + 11'd896, wf, 29'b0};
    end
  end

  // narrowing path
  logic        ns;
  logic [10:0] ne;
  logic [51:0] nf;
  assign ns = operand[63];
  assign ne = operand[62:52];
  assign nf = operand[51:0];

  logic [7:0]  nexp;
  logic        ng, nst, nup;
  logic [30:0] nsum;
  assign nexp = 8'(ne - 11'd896);
  assign ng   = nf[28];
  assign nst  = |nf[27:0];
  assign nup  = ng & (nst | nf[29]);
  assign nsum = {nexp, nf[51:29]} + 31'(nup);

  logic [10:0] eeff;
  logic [52:0] sig;
  logic [6:0]  sh;
  logic [87:0] tw;
  logic [23:0] tk, tsum;
  logic        tg, tst, tup;
  assign eeff = (ne == 11'd0) ? 11'd1 : ne;
  assign sig  = {ne != 11'd0, nf};
  assign sh   = (eeff < 11'd863) ? 7'd63 : 7'(11'd926 - eeff);
  assign tw   = 88'({sig, 64'b0} >> sh);
  assign tk   = tw[87:64];
  assign tg   = tw[63];
  assign tst  = |tw[62:0];
  assign tup  = tg & (tst | tk[0]);
  assign tsum = tk + 24'(tup);

  logic [31:0] n_res;
  logic        n_inv, n_ovf, n_uf, n_ix;

  always_comb begin
    n_res = 32'b0;
    n_inv = 1'b0;
    n_ovf = 1'b0;
    n_uf  = 1'b0;
    n_ix  = 1'b0;
    if (ne == 11'h7FF) begin
      if (nf == 52'b0) n_res = {ns, 8'hFF, 23'b0};
      else begin
        n_res = {ns, 8'hFF, 1'b1, nf[50:29]};
        n_inv = ~nf[51];
      end
    end else if (ne == 11'd0 && nf == 52'b0) begin
      n_res = {ns, 31'b0};
    end else if (ne > 11'd1150) begin
      n_res = {ns, 8'hFF, 23'b0};
      n_ovf = 1'b1;
      n_ix  = 1'b1;
    end else if (ne >= 11'd897) begin
      if (nsum[30:23] == 8'hFF) begin
        n_res = {ns, 8'hFF, 23'b0};
        n_ovf = 1'b1;
        n_ix  = 1'b1;
      end else begin
        n_res = {ns, nsum};
        n_ix  = ng | nst;
      end
    end else begin
      n_res = {ns, 7'b0, tsum};
      n_ix  = tg | tst;
      n_uf  = uf_trap_en | tg | tst;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      result         <= 64'b0;
      flag_invalid   <= 1'b0;
      flag_overflow  <= 1'b0;
      flag_underflow <= 1'b0;
      flag_inexact   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result         <= narrow ? {32'b0, n_res} : w_res;
        flag_invalid   <= narrow ? n_inv : w_inv;
        flag_overflow  <= narrow & n_ovf;
        flag_underflow <= narrow & n_uf;
        flag_inexact   <= narrow & n_ix;
      end
    end
  end

endmodule

module fmt_convert_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        narrow,
  input logic        uf_trap_en,
  input logic [63:0] operand,
  input logic        out_valid,
  input logic [63:0] result,
  input logic        flag_invalid,
  input logic        flag_overflow,
  input logic        flag_underflow,
  input logic        flag_inexact
);

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  // R6
  ovf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flag_overflow |-> flag_inexact && result[30:23] == 8'hFF);

  // R9
  uf_untrapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flag_underflow && !$past(uf_trap_en) |-> flag_inexact);

  // R2
  widen_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !$past(narrow) |-> !flag_overflow && !flag_underflow && !flag_inexact);

  // R11
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(narrow) |-> result[63:32] == 32'b0);

  // R4
  narrow_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(narrow) && result[30:23] == 8'hFF && result[22:0] != 23'b0
    |-> result[22]);

  // R3
  widen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !$past(narrow) && result[62:52] == 11'h7FF && result[51:0] != 52'b0
    |-> result[51]);

endmodule

bind fmt_convert fmt_convert_chk u_fmt_convert_chk (.*);

// File: tb/test_fmt_convert.sv
module test_fmt_convert;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, narrow = 1'b0, uf_trap_en = 1'b0;
  logic [63:0] operand = 64'b0;
  logic out_valid, flag_invalid, flag_overflow, flag_underflow, flag_inexact;
  logic [63:0] result;

  always #(CLK_PERIOD/2) clk = ~clk;

  fmt_convert i_fmt_convert (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .narrow(narrow),
    .uf_trap_en(uf_trap_en), .operand(operand), .out_valid(out_valid),
    .result(result), .flag_invalid(flag_invalid), .flag_overflow(flag_overflow),
    .flag_underflow(flag_underflow), .flag_inexact(flag_inexact));

  typedef struct {
    logic [63:0] res;
    logic [3:0]  fl;
    string       tag;
  } exp_t;

  exp_t q[$];
  int errors = 0, checks = 0;
  logic [63:0] last_res = 64'b0;

  // flags packed as {invalid, overflow, underflow, inexact}
  task automatic send(bit nar, bit trap, logic [63:0] op, logic [63:0] er,
                      logic [3:0] ef, string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; narrow = nar; uf_trap_en = trap; operand = op;
    e.res = er; e.fl = ef; e.tag = tag;
    q.push_back(e);
    last_res = er;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      logic [3:0] got;
      got = {flag_invalid, flag_overflow, flag_underflow, flag_inexact};
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected out_valid: res=%h expected no output", result);
      end else begin
        e = q.pop_front();
        if (result !== e.res || got !== e.fl) begin
          errors++;
          $display("FAIL %s res=%h flags=%b expected res=%h flags=%b",
                   e.tag, result, got, e.res, e.fl);
        end
      end
    end
  end

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    // R12
    if (out_valid !== 1'b0 || result !== 64'b0 ||
        {flag_invalid, flag_overflow, flag_underflow, flag_inexact} !== 4'b0) begin
      errors++;
      $display("FAIL R12 reset: valid=%b res=%h expected 0 0", out_valid, result);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // widening
    send(0, 0, 64'h0000_0000_3F80_0000, 64'h3FF0_0000_0000_0000, 4'b0000, "R2 one");
    send(0, 0, 64'hDEAD_BEEF_C020_0000, 64'hC004_0000_0000_0000, 4'b0000, "R11 R2 upper ignored");
    send(0, 0, 64'h0000_0000_0000_0001, 64'h36A0_0000_0000_0000, 4'b0000, "R2 min subnormal");
    send(0, 0, 64'h0000_0000_007F_FFFF, 64'h380F_FFFF_C000_0000, 4'b0000, "R2 max subnormal");
    send(0, 0, 64'h0000_0000_7F80_0000, 64'h7FF0_0000_0000_0000, 4'b0000, "R10 widen inf");
    send(0, 0, 64'h0000_0000_8000_0000, 64'h8000_0000_0000_0000, 4'b0000, "R10 widen -0");
    send(0, 0, 64'h0000_0000_FFC0_0001, 64'hFFF8_0000_2000_0000, 4'b0000, "R3 qnan");
    send(0, 0, 64'h0000_0000_7F80_0001, 64'h7FF8_0000_2000_0000, 4'b1000, "R3 snan");

    // narrowing, normal range
    send(1, 0, 64'h3FF0_0000_0000_0000, 64'h0000_0000_3F80_0000, 4'b0000, "R5 one");
    send(1, 0, 64'h3FF0_0000_1000_0000, 64'h0000_0000_3F80_0000, 4'b0001, "R5 tie even down");
    send(1, 0, 64'h3FF0_0000_3000_0000, 64'h0000_0000_3F80_0002, 4'b0001, "R5 tie odd up");
    send(1, 0, 64'h3FF0_0000_1000_0001, 64'h0000_0000_3F80_0001, 4'b0001, "R5 above half");
    send(1, 0, 64'h47EF_FFFF_E000_0000, 64'h0000_0000_7F7F_FFFF, 4'b0000, "R5 max single");
    send(1, 0, 64'h47EF_FFFF_F000_0000, 64'h0000_0000_7F80_0000, 4'b0101, "R6 round to inf");
    send(1, 0, 64'hC800_0000_0000_0000, 64'h0000_0000_FF80_0000, 4'b0101, "R6 large neg");
    send(1, 0, 64'hFFF0_0000_0000_0000, 64'h0000_0000_FF80_0000, 4'b0000, "R10 narrow -inf");
    send(1, 0, 64'h8000_0000_0000_0000, 64'h0000_0000_8000_0000, 4'b0000, "R10 narrow -0");

    // narrowing NaN
    send(1, 0, 64'h7FF0_0000_0000_0001, 64'h0000_0000_7FC0_0000, 4'b1000, "R4 snan");
    send(1, 0, 64'hFFF8_0000_2000_0000, 64'h0000_0000_FFC0_0001, 4'b0000, "R4 qnan");

    // narrowing, tiny
    send(1, 1, 64'h37D0_0000_0000_0000, 64'h0000_0000_0008_0000, 4'b0010, "R8 exact tiny trapped");
    send(1, 0, 64'h37D0_0000_0000_0000, 64'h0000_0000_0008_0000, 4'b0000, "R9 exact tiny untrapped");
    send(1, 0, 64'h37D0_0000_0000_0001, 64'h0000_0000_0008_0000, 4'b0011, "R9 inexact tiny");
    send(1, 1, 64'h37D0_0000_0000_0001, 64'h0000_0000_0008_0000, 4'b0011, "R8 inexact tiny");
    send(1, 0, 64'h380F_FFFF_FFFF_FFFF, 64'h0000_0000_0080_0000, 4'b0011, "R7 round to min normal");
    send(1, 1, 64'h3810_0000_0000_0000, 64'h0000_0000_0080_0000, 4'b0000, "R8 min normal not tiny");
    send(1, 0, 64'h3690_0000_0000_0000, 64'h0000_0000_0000_0000, 4'b0011, "R7 half ulp tie to zero");
    send(1, 0, 64'h3698_0000_0000_0000, 64'h0000_0000_0000_0001, 4'b0011, "R7 above half ulp");
    send(1, 0, 64'h8000_0000_0000_0001, 64'h0000_0000_8000_0000, 4'b0011, "R7 double subnormal");

    @(negedge clk);
    in_valid = 1'b0;
    operand = 64'h3FF0_0000_0000_0000;
    repeat (3) @(negedge clk);
    checks++;
    // R1 hold while idle
    if (out_valid !== 1'b0 || result !== last_res) begin
      errors++;
      $display("FAIL R1 idle: valid=%b res=%h expected 0 %h", out_valid, result, last_res);
    end
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R1 missing outputs: pending=%0d expected 0", q.size());
    end
    summary();
  end
endmodule